// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block gathers interrupt source lines into two classes, a normal class and a fast class. Each class drives one interrupt output. Each class has an enable mask that can be changed only by atomic write-to-set and write-to-clear operations. No read-modify-write path exists, so two agents that share the mask cannot overwrite each other's bits. Software can read the unmasked source bits and the masked view of each class separately.

The source inputs are plain levels. Any latching or acknowledging of a source is done by the source itself. The register port is a simple single-cycle request interface. Read data returns one cycle after the request, and so does a flag that marks a read of the write-only set or clear locations. A write to a read-only status location leaves all state unchanged and sets a sticky error bit.

Top module: `irqa_top`

## Requirements
- R1: After reset, both enable masks are zero, both interrupt outputs are low, the sticky error bit is low and no read response is pending.
- R2: The register address has two fields. Bit 2 selects the class (0 normal, 1 fast). Bits 1:0 select the register: 0 enable-set, 1 enable-clear, 2 raw status, 3 masked status. A raw status read returns that class's source input bits as sampled on the request cycle.
- R3: A masked status read returns that class's source bits ANDed bitwise with its enable mask.
- R4: A write to enable-set ORs the write data into that class's enable mask.
- R5: A write to enable-clear removes every bit that is set in the write data from that class's enable mask.
- R6: A read of enable-set or enable-clear returns the current enable mask of the class and raises the read-error flag together with the response. Status reads return with the read-error flag low.
- R7: A write to either status register changes neither enable mask nor either interrupt output, and it sets the sticky error bit, which then stays set until reset.
- R8: Each interrupt output is the OR of its class's masked status. The output is registered and takes the new value on the clock edge that samples a source change.
- R9: A write to an enable mask affects the interrupt output on the same clock edge that updates the mask.
- R10: An enable write to one class leaves the other class's mask and output unchanged.
- R11: The read-valid output is high for exactly the one cycle after each read request and is never raised by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_norm_i | input | SRC_W | Normal-class source levels |
| src_fast_i | input | SRC_W | Fast-class source levels |
| bus_valid_i | input | 1 | Register request strobe |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 3 | Register address (class bit 2, register bits 1:0) |
| bus_wdata_i | input | SRC_W | Write data |
| bus_rdata_o | output | SRC_W | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read response strobe |
| bus_rerr_o | output | 1 | Read of a write-only location |
| err_sticky_o | output | 1 | Sticky flag for a write to a status register |
| irq_norm_o | output | 1 | Normal-class combined interrupt |
| irq_fast_o | output | 1 | Fast-class combined interrupt |

## Verification
The bench builds the block with SRC_W set to 8 and the registered output variant. With this setting the bench can walk all 256 enable masks in each class, each paired with a source pattern computed from the mask, and it compares every status read and both outputs against arithmetic expectations. The narrow width also lets the bench check the set and clear rules on overlapping bit groups. It checks the same-edge output update on every mask change and the one-edge delay after a source change.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
   localparam int N_CLASS = 2;
   localparam int ADDR_W  = 3;

   typedef enum logic [1:0] {
      SEL_EN_SET = 2'd0,
      SEL_EN_CLR = 2'd1,
      SEL_RAW    = 2'd2,
      SEL_MASKED = 2'd3
   } irqa_sel_e;
endpackage

// File: rtl/irqa_decode.sv
module irqa_decode
   import irqa_pkg::*;
(
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [ADDR_W-1:0]   bus_addr,
   output logic [N_CLASS-1:0]  set_we,
   output logic [N_CLASS-1:0]  clr_we,
   output logic                illegal_wr,
   output logic                rd_req,
   output logic                rd_class,
   output irqa_sel_e           rd_sel
);
   irqa_sel_e sel;
   logic      cls;
   logic      wr_req;

   assign sel    = irqa_sel_e'(bus_addr[1:0]);
   assign cls    = bus_addr[2];
   assign wr_req = bus_valid &&  bus_write;
   assign rd_req = bus_valid && !bus_write;

   generate
      for (genvar c = 0; c < N_CLASS; c++) begin : g_cls
         assign set_we[c] = wr_req && (cls == 1'(c)) && (sel == SEL_EN_SET);
         assign clr_we[c] = wr_req && (cls == 1'(c)) && (sel == SEL_EN_CLR);
      end
   endgenerate

   assign illegal_wr = wr_req && ((sel == SEL_RAW) || (sel == SEL_MASKED));
   assign rd_class   = cls;
   assign rd_sel     = sel;
endmodule

// File: rtl/irqa_mask_bank.sv
module irqa_mask_bank #(
   parameter int SRC_W      = 32,
   parameter bit OUTPUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [SRC_W-1:0] wdata,
   input  logic [SRC_W-1:0] src,
   output logic [SRC_W-1:0] en_q,
   output logic [SRC_W-1:0] masked,
   output logic             irq
);
   logic [SRC_W-1:0] en_d;

   always_comb begin
      en_d = en_q;
      if (set_we) en_d = en_d | wdata;
      if (clr_we) en_d = en_d & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   assign masked = src & en_q;

   generate
      if (OUTPUT_REG) begin : g_reg_out
         logic irq_q;
         // the next mask feeds the flop so a mask write acts on its own edge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |(src & en_d);
         end
         assign irq = irq_q;
      end else begin : g_comb_out
         assign irq = |masked;
      end
   endgenerate
endmodule

// File: rtl/irqa_readmux.sv
module irqa_readmux
   import irqa_pkg::*;
#(
   parameter int SRC_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rd_req,
   input  logic                            rd_class,
   input  irqa_sel_e                       rd_sel,
   input  logic [N_CLASS-1:0][SRC_W-1:0]   src_all,
   input  logic [N_CLASS-1:0][SRC_W-1:0]   en_all,
   input  logic [N_CLASS-1:0][SRC_W-1:0]   masked_all,
   output logic [SRC_W-1:0]                rdata,
   output logic                            rvalid,
   output logic                            rerr
);
   logic [SRC_W-1:0] rd_val;
   logic             rd_bad;

   always_comb begin
      rd_val = '0;
      rd_bad = 1'b0;
      unique case (rd_sel)
         SEL_EN_SET, SEL_EN_CLR: begin
            rd_val = en_all[rd_class];
            rd_bad = 1'b1;
         end
         SEL_RAW:    rd_val = src_all[rd_class];
         SEL_MASKED: rd_val = masked_all[rd_class];
         default:    rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
         rerr   <= 1'b0;
      end else begin
         rvalid <= rd_req;
         rerr   <= rd_req && rd_bad;
         if (rd_req) rdata <= rd_val;
      end
   end
endmodule

// File: rtl/irqa_top.sv
module irqa_top
   import irqa_pkg::*;
#(
   parameter int SRC_W      = 32,
   parameter bit OUTPUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  src_norm_i,
   input  logic [SRC_W-1:0]  src_fast_i,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [SRC_W-1:0]  bus_wdata_i,
   output logic [SRC_W-1:0]  bus_rdata_o,
   output logic              bus_rvalid_o,
   output logic              bus_rerr_o,
   output logic              err_sticky_o,
   output logic              irq_norm_o,
   output logic              irq_fast_o
);
   generate
      if (SRC_W < 1 || SRC_W > 64) begin : g_bad_width
         $error("irqa_top: SRC_W must lie in 1..64");
      end
   endgenerate

   logic [N_CLASS-1:0][SRC_W-1:0] src_all;
   logic [N_CLASS-1:0][SRC_W-1:0] en_all;
   logic [N_CLASS-1:0][SRC_W-1:0] masked_all;
   logic [N_CLASS-1:0]            irq_all;
   logic [N_CLASS-1:0]            set_we;
   logic [N_CLASS-1:0]            clr_we;
   logic                          illegal_wr;
   logic                          rd_req;
   logic                          rd_class;
   irqa_sel_e                     rd_sel;
   logic                          err_q;

   assign src_all[0] = src_norm_i;
   assign src_all[1] = src_fast_i;

   irqa_decode u_dec (
      .bus_valid  (bus_valid_i),
      .bus_write  (bus_write_i),
      .bus_addr   (bus_addr_i),
      .set_we     (set_we),
      .clr_we     (clr_we),
      .illegal_wr (illegal_wr),
      .rd_req     (rd_req),
      .rd_class   (rd_class),
      .rd_sel     (rd_sel)
   );

   generate
      for (genvar c = 0; c < N_CLASS; c++) begin : g_bank
         irqa_mask_bank #(.SRC_W(SRC_W), .OUTPUT_REG(OUTPUT_REG)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_we[c]),
            .clr_we (clr_we[c]),
            .wdata  (bus_wdata_i),
            .src    (src_all[c]),
            .en_q   (en_all[c]),
            .masked (masked_all[c]),
            .irq    (irq_all[c])
         );
      end
   endgenerate

   irqa_readmux #(.SRC_W(SRC_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (rd_req),
      .rd_class   (rd_class),
      .rd_sel     (rd_sel),
      .src_all    (src_all),
      .en_all     (en_all),
      .masked_all (masked_all),
      .rdata      (bus_rdata_o),
      .rvalid     (bus_rvalid_o),
      .rerr       (bus_rerr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_q | illegal_wr;
   end

   assign err_sticky_o = err_q;
   assign irq_norm_o   = irq_all[0];
   assign irq_fast_o   = irq_all[1];
endmodule

// File: rtl/irqa_checker.sv
module irqa_checker #(
   parameter int SRC_W      = 32,
   parameter bit OUTPUT_REG = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_valid_i,
   input logic                  bus_write_i,
   input logic [2:0]            bus_addr_i,
   input logic [SRC_W-1:0]      bus_wdata_i,
   input logic [SRC_W-1:0]      src_norm_i,
   input logic [SRC_W-1:0]      src_fast_i,
   input logic                  bus_rvalid_o,
   input logic                  bus_rerr_o,
   input logic                  err_sticky_o,
   input logic                  irq_norm_o,
   input logic                  irq_fast_o,
   input logic [1:0][SRC_W-1:0] en_all
);
   logic status_wr;
   assign status_wr = bus_valid_i && bus_write_i && bus_addr_i[1];

   p_set_ors_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid_i && bus_write_i && bus_addr_i == 3'b000)
      |=> ((en_all[0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

   p_clr_removes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid_i && bus_write_i && bus_addr_i == 3'b101)
      |=> ((en_all[1] & $past(bus_wdata_i)) == '0));

   p_rerr_with_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rerr_o |-> bus_rvalid_o);

   p_status_wr_keeps_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status_wr |=> ($stable(en_all) && err_sticky_o));

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky_o |=> err_sticky_o);

   p_rvalid_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);

   p_no_rvalid_else_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid_i && !bus_write_i) |=> !bus_rvalid_o);

   generate
      if (OUTPUT_REG) begin : g_reg
         p_irq_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_norm_o == |($past(src_norm_i) & en_all[0])));
         p_irq_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_fast_o == |($past(src_fast_i) & en_all[1])));
      end else begin : g_comb
         p_irq_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_norm_o == |(src_norm_i & en_all[0]));
         p_irq_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq_fast_o == |(src_fast_i & en_all[1]));
      end
   endgenerate
endmodule

bind irqa_top irqa_checker #(.SRC_W(SRC_W), .OUTPUT_REG(OUTPUT_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_valid_i  (bus_valid_i),
   .bus_write_i  (bus_write_i),
   .bus_addr_i   (bus_addr_i),
   .bus_wdata_i  (bus_wdata_i),
   .src_norm_i   (src_norm_i),
   .src_fast_i   (src_fast_i),
   .bus_rvalid_o (bus_rvalid_o),
   .bus_rerr_o   (bus_rerr_o),
   .err_sticky_o (err_sticky_o),
   .irq_norm_o   (irq_norm_o),
   .irq_fast_o   (irq_fast_o),
   .en_all       (en_all)
);

// File: tb/tb_irqa_top.sv
`timescale 1ns/1ps
module tb_irqa_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] src_norm = '0;
   logic [W-1:0] src_fast = '0;
   logic         bv = 1'b0;
   logic         bw = 1'b0;
   logic [2:0]   ba = '0;
   logic [W-1:0] bwd = '0;
   logic [W-1:0] rdata;
   logic         rvalid, rerr, err_sticky, irq_n, irq_f;

   int checks = 0;
   int fails  = 0;
   logic [W-1:0] en_model [2];

   always #2 clk = ~clk;

   irqa_top #(.SRC_W(W), .OUTPUT_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .src_norm_i(src_norm), .src_fast_i(src_fast),
      .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bwd),
      .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .bus_rerr_o(rerr),
      .err_sticky_o(err_sticky), .irq_norm_o(irq_n), .irq_fast_o(irq_f)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic cls, input logic [1:0] sel, input logic [W-1:0] d);
      @(negedge clk);
      bv = 1'b1; bw = 1'b1; ba = {cls, sel}; bwd = d;
      @(negedge clk);
      bv = 1'b0; bw = 1'b0;
   endtask

   task automatic rd(input logic cls, input logic [1:0] sel,
                     output logic [W-1:0] d, output logic e, output logic v);
      @(negedge clk);
      bv = 1'b1; bw = 1'b0; ba = {cls, sel};
      @(negedge clk);
      bv = 1'b0;
      d = rdata; e = rerr; v = rvalid;
   endtask

   function automatic logic irq_of(input logic cls);
      return cls ? irq_f : irq_n;
   endfunction

   initial begin
      repeat (400000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] d;
      logic e, v;
      en_model[0] = '0; en_model[1] = '0;
      repeat (3) @(negedge clk);
      chk("R1 irq_norm", 32'(irq_n), 0);
      chk("R1 irq_fast", 32'(irq_f), 0);
      chk("R1 err", 32'(err_sticky), 0);
      chk("R1 rvalid", 32'(rvalid), 0);
      rst_n = 1'b1;
      for (int c = 0; c < 2; c++) begin
         rd(1'(c), 2'd0, d, e, v);
         chk("R1 enable zero", 32'(d), 0);
         chk("R6 rerr on set read", 32'(e), 1);
         chk("R11 rvalid", 32'(v), 1);
      end

      // sweep every mask in each class
      for (int c = 0; c < 2; c++) begin
         for (int m = 0; m < 256; m++) begin
            logic [W-1:0] s;
            logic [W-1:0] mm;
            s  = W'((m * 37 + 5) ^ (c * 90));
            mm = W'(m);
            if (c == 0) begin src_norm = s; src_fast = ~s; end
            else        begin src_fast = s; src_norm = ~s; end
            wr(1'(c), 2'd1, 8'hFF);
            wr(1'(c), 2'd0, mm);
            en_model[c] = mm;
            chk("R9 irq after mask write", 32'(irq_of(1'(c))), 32'(|(s & mm)));
            chk("R11 no rvalid on write", 32'(rvalid), 0);
            rd(1'(c), 2'd2, d, e, v);
            chk("R2 raw", 32'(d), 32'(s));
            chk("R6 rerr low raw", 32'(e), 0);
            rd(1'(c), 2'd3, d, e, v);
            chk("R3 masked", 32'(d), 32'(s & mm));
            rd(1'(c), 2'd1, d, e, v);
            chk("R6 clr read mask", 32'(d), 32'(mm));
            chk("R6 rerr on clr read", 32'(e), 1);
            if ((m % 16) == 3) begin
               wr(1'(c), 2'd0, 8'h0F);
               en_model[c] = en_model[c] | 8'h0F;
               rd(1'(c), 2'd0, d, e, v);
               chk("R4 set ors", 32'(d), 32'(en_model[c]));
               wr(1'(c), 2'd1, 8'h3C);
               en_model[c] = en_model[c] & ~8'h3C;
               rd(1'(c), 2'd0, d, e, v);
               chk("R5 clear removes", 32'(d), 32'(en_model[c]));
               chk("R8 irq matches", 32'(irq_of(1'(c))), 32'(|(s & en_model[c])));
               rd(1'(1 - c), 2'd0, d, e, v);
               chk("R10 other class mask", 32'(d), 32'(en_model[1 - c]));
               chk("R11 rvalid drops", 32'(rvalid), 1);
               @(negedge clk);
               chk("R11 rvalid one cycle", 32'(rvalid), 0);
            end
         end
      end
      chk("R7 no false sticky", 32'(err_sticky), 0);

      // source change timing, normal class
      wr(1'b0, 2'd0, 8'hFF); en_model[0] = 8'hFF;
      src_norm = '0;
      @(negedge clk);
      chk("R8 irq low", 32'(irq_n), 0);
      src_norm = 8'h10;
      #1;
      chk("R8 irq waits for edge", 32'(irq_n), 0);
      @(negedge clk);
      chk("R8 irq rises", 32'(irq_n), 1);
      // class isolation on outputs
      src_fast = 8'h01;
      wr(1'b1, 2'd1, 8'hFF); en_model[1] = '0;
      chk("R10 norm irq kept", 32'(irq_n), 1);
      chk("R10 fast irq low", 32'(irq_f), 0);

      // illegal status writes
      wr(1'b0, 2'd2, 8'h00);
      chk("R7 sticky set", 32'(err_sticky), 1);
      wr(1'b0, 2'd3, 8'h00);
      wr(1'b1, 2'd2, 8'hFF);
      wr(1'b1, 2'd3, 8'hFF);
      chk("R7 irq norm unchanged", 32'(irq_n), 1);
      chk("R7 irq fast unchanged", 32'(irq_f), 0);
      rd(1'b0, 2'd0, d, e, v);
      chk("R7 norm mask unchanged", 32'(d), 32'(en_model[0]));
      rd(1'b1, 2'd1, d, e, v);
      chk("R7 fast mask unchanged", 32'(d), 32'(en_model[1]));
      repeat (3) @(negedge clk);
      chk("R7 sticky holds", 32'(err_sticky), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule